// File: doc/BRIEF.md
# Four-Way Word Cache Controller

This block is a per-processor buffer store for 36-bit words. It sits between a processor port and a slow main-storage port. The store has 512 sets. Each set has four ways, and each way holds a block of four consecutive words. Read hits are answered one cycle after the request.

On a read miss the block is brought in from main storage one word at a time. The word the processor asked for comes first. The processor receives that word as soon as it arrives, and the remaining three words keep filling behind it. Writes always go through to main storage, and they also update the cached word when it is present.

Replacement inside a set follows a pair-tree least-recently-used policy. A per-block disable flag lets faulty blocks be retired. A disabled block is never hit and never filled. When every block of a set is disabled, reads to that set are served directly from main storage and nothing is cached.

Top module: `wcache_ctrl`

## Requirements
- R1: A 24-bit word address splits into tag (bits 23:11), set (bits 10:2) and word offset (bits 1:0). The store has 512 sets of four ways, each way holding four 36-bit words. A block address is resident in at most one way of its set.
- R2: A read miss performs four main-storage read transfers, one word each, at offsets o, o+1, o+2, o+3 modulo 4 within the aligned block, where o is the requested offset. The processor receives the word main storage returned for its address.
- R3: On a filling miss, `cpu_ack` with the requested word comes in the cycle after the first main-storage transfer completes, while `cpu_ready` is still low because the fill is in progress.
- R4: A read to a resident, enabled block raises `cpu_ack` with the cached word in the cycle after the request, with no main-storage transfer. After a fill, all four words of that block hit.
- R5: The victim way comes from three tree bits per set. A top bit selects the pair of ways {0,1} or {2,3} (0 selects {0,1}). Each pair bit selects the way inside its pair (0 selects the lower way). Every read hit, write hit and completed fill sets the bits to point away from the way just used. All bits are zero after reset.
- R6: A `flag_wr` pulse sets or clears the disable flag of block (`flag_set`, `flag_way`) and invalidates that block. A disabled block never hits. Victim selection skips a pair whose two ways are both disabled and, inside a pair, a disabled way.
- R7: When all four ways of a set are disabled, a read performs exactly one main-storage transfer for the requested word, returns it, and caches nothing.
- R8: A write performs one main-storage write transfer with the request's address and data, and `cpu_ack` follows in the cycle after that transfer. A write hit updates the cached word and counts as a use. A write miss allocates nothing.
- R9: After reset every block is invalid and enabled, `cpu_ready` is high, and `cpu_ack` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, taken when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 24 | Word address |
| cpu_wdata | input | 36 | Write data |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 36 | Read data, valid with `cpu_ack` |
| mem_req | output | 1 | Main-storage transfer request, held until `mem_ack` |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 24 | Transfer word address |
| mem_wdata | output | 36 | Transfer write data |
| mem_ack | input | 1 | Transfer complete (read data valid) |
| mem_rdata | input | 36 | Main-storage read data |
| flag_wr | input | 1 | Write one block disable flag |
| flag_set | input | 9 | Set index of the flag |
| flag_way | input | 2 | Way of the flag |
| flag_bad | input | 1 | 1 = disable the block, 0 = enable it |

## Verification
The bench keeps its own model of tags, tree bits and disable flags. It compares every access's hit or miss, transfer count and data against that model. Directed sequences target a miss in the middle of a block, which exposes a fill that starts at offset 0 or fails to wrap. They also target a fifth tag in a full set after a hit, where a wrong tree update evicts a recently used way, and a disabled way holding live data, which a faulty design would still hit. A set with all four ways off must stay uncached; a design that fills a disabled way would show four transfers instead of one. Write hits followed by reads catch a store that is not updated, and write misses followed by reads catch a write that allocates.

// File: rtl/wcache_pkg.sv
package wcache_pkg;

  typedef logic [1:0] way_t;

  // Tree bits: [2] selects the victim pair, [0] the victim inside {0,1}, [1] inside {2,3}.
  function automatic way_t plru_pick(input logic [2:0] tree, input logic [3:0] off);
    logic p;
    way_t w;
    p = tree[2];
    if (off[{p, 1'b0}] && off[{p, 1'b1}]) p = ~p;
    w = {p, (p ? tree[1] : tree[0])};
    if (off[w]) w[0] = ~w[0];
    return w;
  endfunction

  function automatic logic [2:0] plru_use(input logic [2:0] tree, input way_t w);
    logic [2:0] n;
    n = tree;
    n[2] = ~w[1];
    if (w[1]) n[1] = ~w[0];
    else      n[0] = ~w[0];
    return n;
  endfunction

endpackage

// File: rtl/wcache_way.sv
module wcache_way #(
  parameter int TAG_W  = 13,
  parameter int SET_W  = 9,
  parameter int OFF_W  = 2,
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_word,
  input  logic              word_we,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              tag_we,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              clr_a,
  input  logic [SET_W-1:0]  clr_a_set,
  input  logic              clr_b,
  input  logic [SET_W-1:0]  clr_b_set
);
  localparam int SETS  = 1 << SET_W;
  localparam int WORDS = SETS << OFF_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [WORD_W-1:0] data_q [WORDS];

  assign rd_tag   = tag_q[rd_set];
  assign rd_valid = valid_q[rd_set];
  assign rd_word  = data_q[{rd_set, rd_off}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      if (tag_we) valid_q[wr_set]    <= 1'b1;
      if (clr_a)  valid_q[clr_a_set] <= 1'b0;
      if (clr_b)  valid_q[clr_b_set] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (tag_we)  tag_q[wr_set] <= wr_tag;
    if (word_we) data_q[{wr_set, wr_off}] <= wr_word;
  end

endmodule

// File: rtl/wcache_repl.sv
module wcache_repl
  import wcache_pkg::*;
#(
  parameter int SET_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lk_set,
  output logic [2:0]       lk_tree,
  output logic [3:0]       lk_off,
  input  logic             use_en,
  input  logic [SET_W-1:0] use_set,
  input  way_t             use_way,
  input  logic             flag_wr,
  input  logic [SET_W-1:0] flag_set,
  input  way_t             flag_way,
  input  logic             flag_bad
);
  localparam int SETS = 1 << SET_W;

  logic [2:0] tree_q [SETS];
  logic [3:0] off_q  [SETS];

  assign lk_tree = tree_q[lk_set];
  assign lk_off  = off_q[lk_set];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tree_q[s] <= '0;
        off_q[s]  <= '0;
      end
    end else begin
      if (use_en)  tree_q[use_set] <= plru_use(tree_q[use_set], use_way);
      if (flag_wr) off_q[flag_set][flag_way] <= flag_bad;
    end
  end

  AST_USE_POINTS_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
    use_en |=> (plru_pick(tree_q[$past(use_set)], 4'b0000) != $past(use_way))); // R5

endmodule

// File: rtl/wcache_ctrl.sv
module wcache_ctrl
  import wcache_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 36,
  parameter int SET_W  = 9,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_ack,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              flag_wr,
  input  logic [SET_W-1:0]  flag_set,
  input  logic [1:0]        flag_way,
  input  logic              flag_bad
);
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
  localparam int WAYS   = 4;
  localparam logic [OFF_W-1:0] LAST = '1;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_UNC, S_WR} st_t;

  st_t               st_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [WORD_W-1:0] req_wdata_q;
  way_t              vict_q;
  logic [OFF_W-1:0]  cnt_q;
  logic              ack_q;
  logic [WORD_W-1:0] rdata_q;

  wire [TAG_W-1:0] cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [SET_W-1:0] cpu_set = cpu_addr[OFF_W +: SET_W];
  wire [OFF_W-1:0] cpu_off = cpu_addr[OFF_W-1:0];
  wire [TAG_W-1:0] req_tag = req_addr_q[ADDR_W-1 -: TAG_W];
  wire [SET_W-1:0] req_set = req_addr_q[OFF_W +: SET_W];
  wire [OFF_W-1:0] req_off = req_addr_q[OFF_W-1:0];
  wire [OFF_W-1:0] fill_off = req_off + cnt_q;

  // Named internal events
  logic [TAG_W-1:0]  way_tag   [WAYS];
  logic [WORD_W-1:0] way_word  [WAYS];
  logic [WAYS-1:0]   way_valid;
  logic [WAYS-1:0]   hit_vec;
  logic [2:0]        lk_tree;
  logic [3:0]        lk_off;
  way_t              hit_way, victim;
  logic              hit, all_off, accept, fill_done, use_en;

  assign accept    = cpu_req && (st_q == S_IDLE);
  assign hit       = |hit_vec;
  assign all_off   = &lk_off;
  assign victim    = plru_pick(lk_tree, lk_off);
  assign fill_done = (st_q == S_FILL) && mem_ack && (cnt_q == LAST);
  assign use_en    = (accept && hit) || fill_done;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = way_valid[w] && (way_tag[w] == cpu_tag) && !lk_off[w];
      if (hit_vec[w]) hit_way = way_t'(w);
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    wcache_way #(.TAG_W(TAG_W), .SET_W(SET_W), .OFF_W(OFF_W), .WORD_W(WORD_W)) u_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (cpu_set),
      .rd_off   (cpu_off),
      .rd_tag   (way_tag[w]),
      .rd_valid (way_valid[w]),
      .rd_word  (way_word[w]),
      .word_we  (((st_q == S_FILL) && mem_ack && (vict_q == way_t'(w))) ||
                 (accept && cpu_we && hit_vec[w])),
      .wr_set   ((st_q == S_FILL) ? req_set : cpu_set),
      .wr_off   ((st_q == S_FILL) ? fill_off : cpu_off),
      .wr_word  ((st_q == S_FILL) ? mem_rdata : cpu_wdata),
      .tag_we   (fill_done && (vict_q == way_t'(w))),
      .wr_tag   (req_tag),
      .clr_a    (accept && !cpu_we && !hit && !all_off && (victim == way_t'(w))),
      .clr_a_set(cpu_set),
      .clr_b    (flag_wr && (flag_way == way_t'(w))),
      .clr_b_set(flag_set)
    );
  end

  wcache_repl #(.SET_W(SET_W)) u_repl (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_set  (cpu_set),
    .lk_tree (lk_tree),
    .lk_off  (lk_off),
    .use_en  (use_en),
    .use_set (fill_done ? req_set : cpu_set),
    .use_way (fill_done ? vict_q : hit_way),
    .flag_wr (flag_wr),
    .flag_set(flag_set),
    .flag_way(flag_way),
    .flag_bad(flag_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      vict_q      <= '0;
      cnt_q       <= '0;
      ack_q       <= 1'b0;
      rdata_q     <= '0;
    end else begin
      ack_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (accept) begin
          req_addr_q  <= cpu_addr;
          req_wdata_q <= cpu_wdata;
          cnt_q       <= '0;
          vict_q      <= victim;
          if (cpu_we)       st_q <= S_WR;
          else if (hit)     begin ack_q <= 1'b1; rdata_q <= way_word[hit_way]; end
          else if (all_off) st_q <= S_UNC;
          else              st_q <= S_FILL;
        end
        S_FILL: if (mem_ack) begin
          if (cnt_q == '0) begin ack_q <= 1'b1; rdata_q <= mem_rdata; end
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) st_q <= S_IDLE;
        end
        S_UNC: if (mem_ack) begin
          ack_q   <= 1'b1;
          rdata_q <= mem_rdata;
          st_q    <= S_IDLE;
        end
        S_WR: if (mem_ack) begin
          ack_q <= 1'b1;
          st_q  <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cpu_ready = (st_q == S_IDLE);
  assign cpu_ack   = ack_q;
  assign cpu_rdata = rdata_q;
  assign mem_req   = (st_q != S_IDLE);
  assign mem_we    = (st_q == S_WR);
  assign mem_addr  = (st_q == S_FILL) ? {req_tag, req_set, fill_off} : req_addr_q;
  assign mem_wdata = req_wdata_q;

  AST_ONE_WAY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R1
  AST_MISS_STARTS_AT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cpu_we && !hit) |=> (mem_req && !mem_we && mem_addr == $past(cpu_addr))); // R2
  AST_EARLY_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_FILL && cnt_q == '0 && mem_ack) |=> (cpu_ack && !cpu_ready)); // R3
  AST_HIT_NO_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cpu_we && hit) |=> (cpu_ack && !mem_req)); // R4
  AST_VICTIM_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cpu_we && !hit && !all_off) |-> !lk_off[victim]); // R6
  AST_UNCACHED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_UNC && mem_ack) |=> (cpu_ack && cpu_ready)); // R7
  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cpu_we) |=> (mem_req && mem_we && mem_wdata == $past(cpu_wdata) &&
                            mem_addr == $past(cpu_addr))); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) |-> (cpu_ready && !cpu_ack && !mem_req)); // R9

endmodule

// File: tb/wcache_ctrl_test.sv
module wcache_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [35:0] cpu_wdata = '0;
  logic        cpu_ready, cpu_ack;
  logic [35:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [35:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [35:0] mem_rdata = '0;
  logic        flag_wr = 1'b0;
  logic [8:0]  flag_set = '0;
  logic [1:0]  flag_way = '0;
  logic        flag_bad = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wcache_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .flag_wr(flag_wr), .flag_set(flag_set), .flag_way(flag_way), .flag_bad(flag_bad)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- main-storage model ----------------
  logic [35:0] shm [int];
  int          n_xfer;
  logic [23:0] log_addr [8];
  bit          log_we [8];
  logic [35:0] log_data [8];

  function automatic logic [35:0] mem_val(input logic [23:0] a);
    if (shm.exists(int'(a))) return shm[int'(a)];
    return {a[11:0] ^ 12'h9C3, a};
  endfunction

  initial begin
    int waitc;
    int lat;
    waitc = 0;
    lat = 1;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        waitc = 0;
        lat = 1 + int'($urandom_range(2));
      end else if (mem_req) begin
        if (waitc >= lat) begin
          if (n_xfer < 8) begin
            log_addr[n_xfer] = mem_addr;
            log_we[n_xfer]   = mem_we;
            log_data[n_xfer] = mem_wdata;
          end
          n_xfer++;
          if (mem_we) shm[int'(mem_addr)] = mem_wdata;
          else        mem_rdata = mem_val(mem_addr);
          mem_ack = 1'b1;
        end else waitc++;
      end
    end
  end

  // ---------------- cache state model ----------------
  bit          m_valid [512][4];
  logic [12:0] m_tag   [512][4];
  logic [2:0]  m_tree  [512];
  logic [3:0]  m_off   [512];

  function automatic int b_victim(input logic [2:0] t, input logic [3:0] d);
    int base;
    int pick;
    base = t[2] ? 2 : 0;
    if (d[base] && d[base+1]) base = 2 - base;
    pick = base + ((base == 2) ? int'(t[1]) : int'(t[0]));
    if (d[pick]) pick = (pick % 2 == 0) ? pick + 1 : pick - 1;
    return pick;
  endfunction

  function automatic logic [2:0] b_touch(input logic [2:0] t, input int w);
    logic [2:0] r;
    r = t;
    r[2] = (w < 2);
    if (w < 2) r[0] = (w == 0);
    else       r[1] = (w == 2);
    return r;
  endfunction

  function automatic int b_lookup(input logic [23:0] a);
    int s;
    s = int'(a[10:2]);
    for (int w = 0; w < 4; w++)
      if (m_valid[s][w] && m_tag[s][w] == a[23:11] && !m_off[s][w]) return w;
    return -1;
  endfunction

  function automatic logic [23:0] mk(input logic [12:0] t, input logic [8:0] s, input logic [1:0] o);
    return {t, s, o};
  endfunction

  // last operation outcome
  int last_xfer;

  task automatic do_flag(input int s, input int w, input bit bad);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    flag_wr = 1'b1; flag_set = 9'(s); flag_way = 2'(w); flag_bad = bad;
    @(negedge clk);
    flag_wr = 1'b0;
    m_off[s][w] = bad;
    m_valid[s][w] = 0;
  endtask

  task automatic do_op(input bit we, input logic [23:0] a, input logic [35:0] wd);
    int s, hw, lat, xa, v;
    bit rdy_at_ack, alloff;
    logic [35:0] got, expd;
    s = int'(a[10:2]);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    hw = b_lookup(a);
    alloff = (m_off[s] == 4'hF);
    expd = we ? wd : mem_val(a);
    n_xfer = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    lat = 1;
    while (!cpu_ack && lat < 300) begin @(negedge clk); lat++; end
    xa = n_xfer; rdy_at_ack = cpu_ready; got = cpu_rdata;
    while (!cpu_ready) @(negedge clk);
    last_xfer = n_xfer;
    if (we) begin
      chk(n_xfer == 1, "R8", "write transfer count", 64'(n_xfer), 64'd1);
      chk(log_we[0] && log_addr[0] == a && log_data[0] == wd, "R8", "write-through address",
          64'(log_addr[0]), 64'(a));
      chk(xa == 1 && rdy_at_ack, "R8", "write ack after transfer", 64'(xa), 64'd1);
      if (hw >= 0) m_tree[s] = b_touch(m_tree[s], hw);
    end else if (hw >= 0) begin
      chk(lat == 1 && n_xfer == 0, "R4", "hit latency/transfers", 64'(lat * 100 + n_xfer), 64'd100);
      chk(got == expd, "R4", "hit data", 64'(got), 64'(expd));
      m_tree[s] = b_touch(m_tree[s], hw);
    end else if (alloff) begin
      chk(n_xfer == 1, "R7", "uncached transfer count", 64'(n_xfer), 64'd1);
      chk(got == expd && log_addr[0] == a, "R7", "uncached data", 64'(got), 64'(expd));
    end else begin
      chk(n_xfer == 4, (m_off[s] != 0) ? "R6" : "R5", "miss transfer count", 64'(n_xfer), 64'd4);
      chk(got == expd, "R2", "miss data", 64'(got), 64'(expd));
      for (int k = 0; k < 4; k++)
        chk(log_addr[k] == {a[23:2], 2'(a[1:0] + 2'(k))} && !log_we[k], "R2", "fill order",
            64'(log_addr[k]), 64'({a[23:2], 2'(a[1:0] + 2'(k))}));
      chk(xa == 1 && !rdy_at_ack, "R3", "early return", 64'(xa * 10 + int'(rdy_at_ack)), 64'd10);
      v = b_victim(m_tree[s], m_off[s]);
      m_valid[s][v] = 1; m_tag[s][v] = a[23:11];
      m_tree[s] = b_touch(m_tree[s], v);
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [8:0]  sets [3];
    logic [12:0] tags [6];
    for (int s = 0; s < 512; s++) begin
      m_tree[s] = '0; m_off[s] = '0;
      for (int w = 0; w < 4; w++) begin m_valid[s][w] = 0; m_tag[s][w] = '0; end
    end
    void'($urandom(32'h5EED_0A11));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(cpu_ready && !cpu_ack && !mem_req, "R9", "reset outputs",
        64'({cpu_ready, cpu_ack, mem_req}), 64'b100);

    // R1/R2/R3: miss in the middle of a block wraps the fill order
    do_op(0, mk(13'h0123, 9'd17, 2'd2), '0);
    // R4: remaining words of the block hit
    for (int o = 0; o < 4; o++) do_op(0, mk(13'h0123, 9'd17, 2'(o)), '0);
    // R1: same set and offset, other tag misses
    do_op(0, mk(13'h0456, 9'd17, 2'd2), '0);
    chk(last_xfer == 4, "R1", "tag compare", 64'(last_xfer), 64'd4);

    // R5: fill a set, touch one way, bring a fifth tag, re-read everything
    for (int t = 1; t <= 4; t++) do_op(0, mk(13'(t), 9'd40, 2'd0), '0);
    do_op(0, mk(13'd1, 9'd40, 2'd3), '0);
    do_op(0, mk(13'd5, 9'd40, 2'd1), '0);
    do_op(0, mk(13'd1, 9'd40, 2'd0), '0);
    chk(last_xfer == 0, "R5", "recently used way kept", 64'(last_xfer), 64'd0);
    for (int t = 2; t <= 5; t++) do_op(0, mk(13'(t), 9'd40, 2'd2), '0);

    // R6: disable a way holding live data, then re-enable it
    do_op(0, mk(13'h0AA, 9'd60, 2'd0), '0);
    do_flag(60, 0, 1);
    do_op(0, mk(13'h0AA, 9'd60, 2'd1), '0);
    chk(last_xfer == 4, "R6", "disabled block not hit", 64'(last_xfer), 64'd4);
    do_flag(60, 0, 0);
    do_flag(60, 2, 1);
    do_flag(60, 3, 1);
    for (int t = 0; t < 4; t++) do_op(0, mk(13'(16 + t), 9'd60, 2'(t)), '0);

    // R7: all ways off, reads stay uncached
    for (int w = 0; w < 4; w++) do_flag(61, w, 1);
    do_op(0, mk(13'h077, 9'd61, 2'd3), '0);
    do_op(0, mk(13'h077, 9'd61, 2'd3), '0);
    chk(last_xfer == 1, "R7", "nothing cached", 64'(last_xfer), 64'd1);

    // R8: write hit updates the store, write miss does not allocate
    do_op(1, mk(13'h0123, 9'd17, 2'd1), 36'hABCDE1234);
    do_op(0, mk(13'h0123, 9'd17, 2'd1), '0);
    chk(last_xfer == 0 && cpu_rdata == 36'hABCDE1234, "R8", "write hit data",
        64'(cpu_rdata), 64'h0ABCDE1234);
    do_op(1, mk(13'h0999, 9'd90, 2'd0), 36'h123456789);
    do_op(0, mk(13'h0999, 9'd90, 2'd0), '0);
    chk(last_xfer == 4, "R8", "write miss no allocate", 64'(last_xfer), 64'd4);

    // Random mix
    sets[0] = 9'd5; sets[1] = 9'd200; sets[2] = 9'd511;
    for (int i = 0; i < 6; i++) tags[i] = 13'(13'h100 + i * 13'h2F1);
    for (int i = 0; i < 400; i++) begin
      logic [23:0] a;
      a = mk(tags[$urandom_range(5)], sets[$urandom_range(2)], 2'($urandom_range(3)));
      if (i % 40 == 39) do_flag(200, int'($urandom_range(3)), bit'($urandom_range(1)));
      if ($urandom_range(3) == 0) do_op(1, a, 36'($urandom()) ^ {4'hA, 32'h0});
      else                        do_op(0, a, '0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule